// File: doc/BRIEF.md
# Serial Register Control Port

This block is a serial-peripheral slave that lets a host processor read and write a small bank of 8-bit configuration registers. The host drives an active-low select, a bit clock and a data line into the block. The block returns data on a data-out line that has a separate output enable, so the pad logic can build the three-state driver. The bus pins are oversampled by the block's own system clock through a synchronizer. Edges of the bit clock are detected in that clock domain, so the whole block runs on one clock.

Every transaction starts with a 7-bit device address and a direction bit. A write then carries a pointer byte, followed by any number of data bytes. A read carries only data bytes, and it starts at the pointer that an earlier write left behind. The pointer advances after each data byte, which allows block access across consecutive registers. Register 1 holds a fixed identity value. Register 2 holds a power-down bit, and this bit is also driven out on its own port. The contents of all registers are brought out on a flat bus for the rest of the chip.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, spi_miso_oe is 0, pwr_dn is 1, the pointer is 00h, register 2 holds 01h, and every other writable register holds 00h.
- R2: Data in is captured on rising bit-clock edges while select is low. spi_miso changes only after a falling bit-clock edge, and its bits are sent MSB first.
- R3: The first byte of a transaction is the device address in bits 7:1 and the direction in bit 0 (0 = write). If the address is not 1001111b, the rest of the transaction is ignored: no register changes and spi_miso_oe stays 0.
- R4: In a write, the second byte loads the pointer. Each later byte is stored in the register that the pointer selects, on the rising edge that completes that byte.
- R5: The pointer increments by one after every complete data byte, in both writes and reads.
- R6: The pointer is 8 bits wide and wraps from FFh to 00h.
- R7: The pointer keeps its value between transactions. A read starts at the pointer left by an earlier write that ended right after the pointer byte.
- R8: In a read, spi_miso_oe rises at the first falling edge after the direction bit, and that edge presents bit 7 of the addressed register.
- R9: spi_miso_oe stays 0 for the whole of a write transaction, and it returns to 0 once select goes high.
- R10: Register 1 is read-only and reads as C0h plus the 4-bit revision parameter (C3h by default). Writes to it have no effect.
- R11: Bit 0 of register 2 drives pwr_dn. While this bit is set, the register contents are kept and all registers can still be written.
- R12: If select goes high in the middle of a byte, that partial byte is discarded. No register is written and the pointer does not change.
- R13: Pointer values at or above NUM_REGS (16 by default) address no register. Writes there are dropped, and reads there return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial bit clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| pwr_dn | output | 1 | Power-down bit, register 2 bit 0 |
| reg_bus | output | NUM_REGS*8 | All register contents; register k sits in bits 8k+7:8k |

## Verification
Two things happen on the rising edge that completes a data byte: the register write (or the reload of the next read byte) and the pointer increment. Writing a block of bytes that starts at FEh makes the wrap to 00h fall on that same edge. Three cases are provoked this way: two dropped writes, then a real store into register 0, then a read that continues from register 1. A behavioural model in the bench steps through the same transactions. Its register image, output enable and read data are compared with the port values on every clock once the pins have settled. The bench also checks the exact bytes the host reads back.

// File: rtl/spi_rcp_pkg.sv
package spi_rcp_pkg;
   localparam logic [6:0] DEV_ADDR  = 7'b1001111;
   localparam logic [3:0] PART_NIB  = 4'b1100;
   localparam int         ID_SLOT   = 1;
   localparam int         PWR_SLOT  = 2;

   typedef enum logic [2:0] {
      PH_ADDR,
      PH_PTR,
      PH_WR,
      PH_RD,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/spi_rcp_sync.sv
module spi_rcp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic cs_n_pin,
   input  logic mosi_pin,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_idle,
   output logic mosi_s
);
   // bit 2 = sclk, bit 1 = cs_n, bit 0 = mosi
   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      logic [2:0] d;
      logic [2:0] q;
      if (g == 0) begin : g_first
         assign d = {sclk_pin, cs_n_pin, mosi_pin};
      end else begin : g_next
         assign d = g_stg[g-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 3'b010;
         else        q <= d;
      end
   end

   logic [2:0] last;
   logic       sclk_prev;
   assign last = g_stg[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= last[2];
   end

   assign cs_idle   = last[1];
   assign mosi_s    = last[0];
   assign sclk_rise =  last[2] & ~sclk_prev & ~last[1];
   assign sclk_fall = ~last[2] &  sclk_prev & ~last[1];
endmodule

// File: rtl/spi_rcp_regs.sv
module spi_rcp_regs
   import spi_rcp_pkg::*;
#(
   parameter int         NUM_REGS = 16,
   parameter logic [3:0] REV      = 4'h3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_ptr,
   input  logic [7:0]            wr_data,
   input  logic [7:0]            rd_ptr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] reg_bus
);
   localparam int         IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam logic [8:0] LIMIT = 9'(NUM_REGS);

   logic [7:0] bank [NUM_REGS];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
      if (k == ID_SLOT) begin : g_id
         assign bank[k] = {PART_NIB, REV};
      end else begin : g_rw
         localparam logic [7:0] INIT = (k == PWR_SLOT) ? 8'h01 : 8'h00;
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           q <= INIT;
            else if (wr_en && wr_ptr == 8'(k))    q <= wr_data;
         end
         assign bank[k] = q;
      end
      assign reg_bus[k*8 +: 8] = bank[k];
   end

   assign rd_data = ({1'b0, rd_ptr} < LIMIT) ? bank[rd_ptr[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/spi_rcp_frame.sv
module spi_rcp_frame
   import spi_rcp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_rise,
   input  logic       sclk_fall,
   input  logic       cs_idle,
   input  logic       mosi_s,
   input  logic [7:0] rd_data,
   output logic       wr_en,
   output logic [7:0] wr_ptr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_ptr,
   output logic       miso,
   output logic       miso_oe,
   output logic       skip
);
   phase_t     phase;
   logic [2:0] cnt;
   logic [6:0] sh;
   logic [7:0] ptr;
   logic [7:0] tx;
   logic [7:0] byte_in;
   logic       byte_done;

   assign byte_in   = {sh, mosi_s};
   assign byte_done = sclk_rise && (cnt == 3'd7);
   assign wr_en     = byte_done && (phase == PH_WR);
   assign wr_ptr    = ptr;
   assign wr_data   = byte_in;
   assign rd_ptr    = (phase == PH_RD) ? ptr + 8'd1 : ptr;
   assign skip      = (phase == PH_SKIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_ADDR;
         cnt     <= '0;
         sh      <= '0;
         ptr     <= '0;
         tx      <= '0;
         miso    <= 1'b0;
         miso_oe <= 1'b0;
      end else if (cs_idle) begin
         phase   <= PH_ADDR;
         cnt     <= '0;
         miso_oe <= 1'b0;
      end else begin
         if (sclk_rise) begin
            cnt <= cnt + 3'd1;
            sh  <= byte_in[6:0];
            if (cnt == 3'd7) begin
               case (phase)
                  PH_ADDR: begin
                     if (byte_in[7:1] != DEV_ADDR) begin
                        phase <= PH_SKIP;
                     end else if (byte_in[0]) begin
                        phase <= PH_RD;
                        tx    <= rd_data;
                     end else begin
                        phase <= PH_PTR;
                     end
                  end
                  PH_PTR: begin
                     ptr   <= byte_in;
                     phase <= PH_WR;
                  end
                  PH_WR: ptr <= ptr + 8'd1;
                  PH_RD: begin
                     ptr <= ptr + 8'd1;
                     tx  <= rd_data;
                  end
                  default: ;
               endcase
            end
         end
         if (sclk_fall && phase == PH_RD) begin
            miso    <= tx[7];
            tx      <= {tx[6:0], 1'b0};
            miso_oe <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
   import spi_rcp_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] REV         = 4'h3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_sclk,
   input  logic                  spi_cs_n,
   input  logic                  spi_mosi,
   output logic                  spi_miso,
   output logic                  spi_miso_oe,
   output logic                  pwr_dn,
   output logic [NUM_REGS*8-1:0] reg_bus
);
   if (NUM_REGS < 3 || NUM_REGS > 256) begin : g_bad_regs
      $error("spi_reg_port: NUM_REGS must lie in 3..256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_reg_port: SYNC_STAGES must be at least 2");
   end

   logic       sclk_rise, sclk_fall, cs_idle, mosi_s;
   logic       wr_en, skip_flag;
   logic [7:0] wr_ptr, wr_data, rd_ptr, rd_data;

   spi_rcp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_pin  (spi_sclk),
      .cs_n_pin  (spi_cs_n),
      .mosi_pin  (spi_mosi),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_idle   (cs_idle),
      .mosi_s    (mosi_s)
   );

   spi_rcp_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .cs_idle   (cs_idle),
      .mosi_s    (mosi_s),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_ptr    (wr_ptr),
      .wr_data   (wr_data),
      .rd_ptr    (rd_ptr),
      .miso      (spi_miso),
      .miso_oe   (spi_miso_oe),
      .skip      (skip_flag)
   );

   spi_rcp_regs #(.NUM_REGS(NUM_REGS), .REV(REV)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_data),
      .rd_ptr  (rd_ptr),
      .rd_data (rd_data),
      .reg_bus (reg_bus)
   );

   assign pwr_dn = reg_bus[PWR_SLOT*8];
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
   parameter int NUM_REGS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs_idle,
   input logic                  sclk_rise,
   input logic                  sclk_fall,
   input logic                  skip,
   input logic                  miso,
   input logic                  miso_oe,
   input logic [NUM_REGS*8-1:0] reg_bus
);
   // R9
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !miso_oe);

   // R2
   miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(miso));

   // R8
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(sclk_fall));

   // R4
   reg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_bus) |-> $past(sclk_rise));

   // R3
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> !miso_oe);
endmodule

bind spi_reg_port spi_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_idle   (cs_idle),
   .sclk_rise (sclk_rise),
   .sclk_fall (sclk_fall),
   .skip      (skip_flag),
   .miso      (spi_miso),
   .miso_oe   (spi_miso_oe),
   .reg_bus   (reg_bus)
);

// File: tb/test_spi_reg_port.sv
`timescale 1ns/1ps
module test_spi_reg_port;
   localparam int NREG   = 16;
   localparam int HALF   = 6;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe, pwr_dn;
   logic [NREG*8-1:0] reg_bus;

   always #2.5 clk = ~clk;

   spi_reg_port #(.NUM_REGS(NREG)) i_spi_reg_port (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .pwr_dn(pwr_dn), .reg_bus(reg_bus)
   );

   int n_chk = 0, n_bad = 0, quiet = 0;
   bit done = 1'b0;

   // behavioural model of the register port
   logic [7:0] mreg [NREG];
   logic [7:0] mptr, mbyte, mtx;
   int         mcnt, mphase; // 0 addr, 1 ptr, 2 write, 3 read, 4 ignore
   logic       exp_oe, exp_miso;

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mread(input logic [7:0] p);
      return (int'(p) < NREG) ? mreg[p] : 8'h00;
   endfunction

   function automatic logic [NREG*8-1:0] mimage();
      logic [NREG*8-1:0] v;
      for (int k = 0; k < NREG; k++) v[k*8 +: 8] = mreg[k];
      return v;
   endfunction

   task automatic model_rise(input logic b);
      mbyte = {mbyte[6:0], b};
      mcnt++;
      if (mcnt == 8) begin
         mcnt = 0;
         case (mphase)
            0: if (mbyte[7:1] != 7'h4F) mphase = 4;
               else if (mbyte[0]) begin mphase = 3; mtx = mread(mptr); end
               else mphase = 1;
            1: begin mptr = mbyte; mphase = 2; end
            2: begin
                  if (int'(mptr) < NREG && mptr != 8'd1) mreg[mptr] = mbyte;
                  mptr = mptr + 8'd1;
               end
            3: begin mptr = mptr + 8'd1; mtx = mread(mptr); end
            default: ;
         endcase
      end
   endtask

   task automatic model_fall();
      if (mphase == 3) begin
         exp_miso = mtx[7];
         mtx      = {mtx[6:0], 1'b0};
         exp_oe   = 1'b1;
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic [7:0] got);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = v[i]; quiet = 0; tick(HALF);
         got[i] = spi_miso;
         spi_sclk = 1'b1; quiet = 0; model_rise(v[i]); tick(HALF);
         spi_sclk = 1'b0; quiet = 0; model_fall(); tick(HALF);
      end
   endtask

   task automatic cs_low();
      spi_cs_n = 1'b0; quiet = 0; tick(HALF);
   endtask

   task automatic cs_high();
      tick(HALF);
      spi_cs_n = 1'b1; quiet = 0;
      mphase = 0; mcnt = 0; exp_oe = 1'b0;
      tick(2*HALF);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d[$]);
      logic [7:0] g;
      cs_low();
      send_byte({a, 1'b0}, g);
      send_byte(p, g);
      foreach (d[i]) send_byte(d[i], g);
      cs_high();
   endtask

   task automatic do_read(input logic [6:0] a, input int n, output logic [7:0] q[$]);
      logic [7:0] g;
      q = {};
      cs_low();
      send_byte({a, 1'b1}, g);
      for (int i = 0; i < n; i++) begin send_byte(8'h00, g); q.push_back(g); end
      cs_high();
   endtask

   // per-clock comparison against the model once the pins have settled
   initial begin
      forever begin
         @(posedge clk); #1;
         if (rst_n && quiet >= SETTLE) begin
            chk(reg_bus == mimage(), "R4 reg_bus", reg_bus, mimage());
            chk(pwr_dn == mreg[2][0], "R11 pwr_dn", pwr_dn, mreg[2][0]);
            chk(spi_miso_oe == exp_oe, "R9 miso_oe", spi_miso_oe, exp_oe);
            if (exp_oe) chk(spi_miso == exp_miso, "R2 miso bit", spi_miso, exp_miso);
         end
         quiet++;
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] rd[$];
      for (int k = 0; k < NREG; k++) mreg[k] = 8'h00;
      mreg[1] = 8'hC3; mreg[2] = 8'h01;
      mptr = 8'h00; mbyte = 8'h00; mtx = 8'h00; mcnt = 0; mphase = 0;
      exp_oe = 1'b0; exp_miso = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(8);

      // R1 reset state
      chk(spi_miso_oe == 1'b0, "R1 oe", spi_miso_oe, 0);
      chk(pwr_dn == 1'b1, "R1 pwr_dn", pwr_dn, 1);
      chk(reg_bus[23:16] == 8'h01, "R1 reg2", reg_bus[23:16], 8'h01);
      chk(reg_bus[7:0] == 8'h00 && reg_bus[127:24] == '0, "R1 others", reg_bus, mimage());
      // R10 identity
      chk(reg_bus[15:8] == 8'hC3, "R10 id", reg_bus[15:8], 8'hC3);

      // R4 R5 R11: block write while power-down is set
      do_write(7'h4F, 8'h04, '{8'hA5, 8'h3C});
      chk(reg_bus[39:32] == 8'hA5 && reg_bus[47:40] == 8'h3C, "R4 block write", reg_bus[47:32], 16'h3CA5);
      chk(pwr_dn == 1'b1, "R11 kept", pwr_dn, 1);

      // R7 R8 R5: pointer-only write then read two bytes
      do_write(7'h4F, 8'h04, '{});
      do_read(7'h4F, 2, rd);
      chk(rd[0] == 8'hA5, "R8 read first", rd[0], 8'hA5);
      chk(rd[1] == 8'h3C, "R5 read next", rd[1], 8'h3C);

      // R10 write to identity register ignored
      do_write(7'h4F, 8'h01, '{8'h55});
      do_write(7'h4F, 8'h01, '{});
      do_read(7'h4F, 1, rd);
      chk(rd[0] == 8'hC3, "R10 read-only", rd[0], 8'hC3);

      // R11 clear power-down
      do_write(7'h4F, 8'h02, '{8'h00});
      chk(pwr_dn == 1'b0, "R11 cleared", pwr_dn, 0);

      // R3 wrong device address: write and read both ignored
      do_write(7'h4E, 8'h04, '{8'hFF});
      chk(reg_bus[39:32] == 8'hA5, "R3 no write", reg_bus[39:32], 8'hA5);
      do_read(7'h2F, 1, rd);
      chk(spi_miso_oe == 1'b0, "R3 oe quiet", spi_miso_oe, 0);

      // R6 R13: block write across the wrap
      do_write(7'h4F, 8'hFE, '{8'h11, 8'h22, 8'h33});
      chk(reg_bus[7:0] == 8'h33, "R6 wrap store", reg_bus[7:0], 8'h33);
      // R7 pointer now 01h, carried over
      do_read(7'h4F, 1, rd);
      chk(rd[0] == 8'hC3, "R7 kept pointer", rd[0], 8'hC3);
      do_write(7'h4F, 8'hFF, '{});
      do_read(7'h4F, 2, rd);
      chk(rd[0] == 8'h00, "R13 out of range", rd[0], 8'h00);
      chk(rd[1] == 8'h33, "R6 read wrap", rd[1], 8'h33);

      // R12 partial byte discarded
      do_write(7'h4F, 8'h06, '{8'h77});
      begin
         logic [7:0] g;
         cs_low();
         send_byte({7'h4F, 1'b0}, g);
         send_byte(8'h06, g);
         for (int i = 0; i < 4; i++) begin
            spi_mosi = 1'b1; quiet = 0; tick(HALF);
            spi_sclk = 1'b1; quiet = 0; model_rise(1'b1); tick(HALF);
            spi_sclk = 1'b0; quiet = 0; model_fall(); tick(HALF);
         end
         cs_high();
      end
      chk(reg_bus[55:48] == 8'h77, "R12 no write", reg_bus[55:48], 8'h77);
      do_read(7'h4F, 1, rd);
      chk(rd[0] == 8'h77, "R12 pointer held", rd[0], 8'h77);

      tick(20);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule